// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block converts transfer requests from inside a processor into clocked cycles on a shared, time-multiplexed address/data bus. A requester presents a transfer kind, a byte address, write data, a byte/word flag, a segment tag and a lock flag. It holds these steady until the block pulses `done`, and on reads it collects the assembled data on `rdata`. On the bus side the block drives the address in the first clock of each cycle and data afterwards. It also drives an address latch strobe, separate active-low read, write and interrupt-acknowledge strobes, direction and memory/IO qualifiers, an active-low transceiver enable, a three-bit cycle status code, the high-byte enable, and segment tag bits on the upper address lines. The block waits on `ready`.

A bus cycle runs through four clocks (T1 to T4). Wait clocks (TW) follow T3 for as long as `ready` is low. A word request at an odd address is broken into two byte cycles, low byte first. The second cycle begins straight after the first cycle's T4. Between requests the block rests in idle clocks (TI). The idle clock in which a request is first seen is the one in which its status code, direction and memory/IO qualifier are presented ahead of T1. The transceiver enable changes in the middle of a clock and is produced by a falling-edge register.

Top module: `muxbus_cycle_seq`

## Requirements
- R1: Every bus cycle spans T1, T2, T3, one TW per clock in which `ready` is sampled low at the end of T3 or TW, and T4. `done` is high only during the T4 of the last cycle of a request.
- R2: `ale` is high for exactly the T1 clock of each cycle and low in every other clock. In T1, `ad_oe` is 1 and `ad_out` carries address bits 15..0. In T1, `a_hi` carries address bits 19..16 for memory kinds and 0 for IO, acknowledge and halt kinds.
- R3: In T2, T3 and every TW, `rd_n` is low for kinds 001, 100 and 101, `wr_n` is low for kinds 010 and 110, and `inta_n` is low for kind 000. In all other clocks the three strobes are high, and halt (011) asserts none of them.
- R4: `den_n` is low for every kind except halt. For kinds that receive data it goes low at the middle of T2, and for writes it goes low at the start of T2. In both cases it returns high at the middle of T4.
- R5: `m_io` is 1 for kinds 100, 101 and 110 and 0 otherwise. `dt_r` is 1 for kinds 010 and 110 and 0 otherwise. Both are valid from the idle clock that precedes T1 through the final T4.
- R6: `bus_status` carries the request kind, with the encoding 000 acknowledge, 001 IO read, 010 IO write, 011 halt, 100 fetch, 101 memory read, 110 memory write. The kind is shown in the idle clock ahead of T1, in T1 and in T2. It is also shown in T3 or TW while `ready` is low, and in a first-half T4. Otherwise the code is 111 (passive).
- R7: `bhe_n` and address bit 0 select the lanes: {0,0} is a whole word, {0,1} is a byte on bits 15..8 at an odd address, and {1,0} is a byte on bits 7..0 at an even address. Write data appears on the selected lane with `ad_oe` high in T2 to T4. For receiving kinds, `ad_oe` is low in T2 to T4.
- R8: A word at an odd address A runs two cycles. The first is at A, carrying the low data byte on bits 15..8. The second is at A+1 (modulo 2^20), carrying the high data byte on bits 7..0. A word at an even address runs one cycle.
- R9: From T2 through T4, `a_hi` carries the two-bit segment tag in bits 1..0 and zero above it.
- R10: With no request pending, each clock is idle: `ale` low, all strobes and `den_n` high, `lock_n` high, and status 111. The same holds while reset is asserted.
- R11: For receiving kinds, `ad_in` is captured on the clock edge that ends the last T3/TW, and the assembled word is on `rdata` while `done` is high. A byte read gives {0, byte}. A word read gives the byte at A+1 above the byte at A, including for split words.
- R12: For a locked request, `lock_n` stays low from the first T1 through the final T4, including the gap between the two halves of a split word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending; held until `done` |
| req_kind | input | 3 | Transfer kind, encoded as the status code |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 for a word transfer, 0 for a byte |
| req_wdata | input | 16 | Write data; a byte uses bits 7..0 |
| req_seg | input | 2 | Segment tag shown in T2 to T4 |
| req_lock | input | 1 | Hold the bus lock for the whole request |
| done | output | 1 | Completion pulse in the final T4 |
| rdata | output | 16 | Assembled read data |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 16 | Data returned on the multiplexed lines |
| a_hi | output | 4 | Upper address in T1, segment tag afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| dt_r | output | 1 | Direction: 1 transmit, 0 receive |
| m_io | output | 1 | 1 memory, 0 IO |
| den_n | output | 1 | Transceiver enable, active low |
| bus_status | output | 3 | Cycle status code |
| bhe_n | output | 1 | High byte enable, active low |
| lock_n | output | 1 | Bus lock, active low |
| ready | input | 1 | Target ready; low inserts wait clocks |

## Verification
The hardest situations to reach combine a split odd-address word with wait clocks in both halves, a lock held across the half boundary, and an address that wraps from the top of the space to zero on the second half. The stimulus requests locked and unlocked odd words at 0xFFFFF and at mid-range addresses with one and two waits. The bench derives its own T-state from `ale` and the `ready` it drove, and checks every output in both halves of each clock. That exposes the half-clock edges of `den_n` and the point in T3 or TW where the status goes passive.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [2:0] {
      K_INTA  = 3'b000,
      K_IORD  = 3'b001,
      K_IOWR  = 3'b010,
      K_HALT  = 3'b011,
      K_FETCH = 3'b100,
      K_MRD   = 3'b101,
      K_MWR   = 3'b110,
      K_NONE  = 3'b111
   } bus_kind_e;

   typedef enum logic [2:0] {S_TI, S_T1, S_T2, S_T3, S_TW, S_T4} tstate_e;

   function automatic logic kind_is_write(input bus_kind_e k);
      return (k == K_IOWR) || (k == K_MWR);
   endfunction

   function automatic logic kind_is_rdstrobe(input bus_kind_e k);
      return (k == K_IORD) || (k == K_MRD) || (k == K_FETCH);
   endfunction

   function automatic logic kind_is_mem(input bus_kind_e k);
      return k[2] && (k != K_NONE);
   endfunction

   function automatic logic kind_has_den(input bus_kind_e k);
      return (k != K_HALT) && (k != K_NONE);
   endfunction

   function automatic logic kind_captures(input bus_kind_e k);
      return kind_is_rdstrobe(k) || (k == K_INTA);
   endfunction
endpackage

// File: rtl/mbs_lane_steer.sv
module mbs_lane_steer #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              word,
   input  logic              second,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_in,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              full_word,
   output logic              bhe_n,
   output logic [DATA_W-1:0] wr_bus,
   output logic [DATA_W/2-1:0] rd_byte
);
   localparam int LANE_W = DATA_W / 2;

   logic [LANE_W-1:0] byte_out;

   always_comb begin
      eff_addr  = base_addr + (second ? ADDR_W'(1) : ADDR_W'(0));
      full_word = word && !base_addr[0];
      bhe_n     = full_word ? 1'b0 : !eff_addr[0];
      byte_out  = second ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0];
      wr_bus    = full_word ? wdata : {byte_out, byte_out};
      rd_byte   = eff_addr[0] ? ad_in[DATA_W-1:LANE_W] : ad_in[LANE_W-1:0];
   end
endmodule

// File: rtl/mbs_den_gen.sv
module mbs_den_gen #(
   parameter bit MID_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic early,
   output logic den_n
);
   generate
      if (MID_EDGE) begin : g_mid
         logic mid_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) mid_q <= 1'b0;
            else        mid_q <= busy;
         end
         assign den_n = ~(early ? (busy | mid_q) : mid_q);
      end else begin : g_full
         logic late_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) late_q <= 1'b0;
            else        late_q <= busy;
         end
         assign den_n = ~(early ? (busy | late_q) : late_q);
      end
   endgenerate
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int SEG_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic              req_lock,
   input  logic              ready,
   input  logic              full_word,
   input  logic [DATA_W/2-1:0] rd_byte,
   input  logic [DATA_W-1:0] ad_in,
   output tstate_e           st,
   output bus_kind_e         cur_kind,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_word,
   output logic [DATA_W-1:0] cur_wdata,
   output logic [SEG_W-1:0]  cur_seg,
   output logic              cur_lock,
   output logic              second,
   output logic              first_of_two,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);
   localparam int LANE_W = DATA_W / 2;

   logic split;

   assign split        = cur_word && cur_addr[0];
   assign first_of_two = split && !second;
   assign done         = (st == S_T4) && !first_of_two;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_TI;
         cur_kind  <= K_NONE;
         cur_addr  <= '0;
         cur_word  <= 1'b0;
         cur_wdata <= '0;
         cur_seg   <= '0;
         cur_lock  <= 1'b0;
         second    <= 1'b0;
         rdata     <= '0;
      end else begin
         case (st)
            S_TI: if (req_valid) begin
               cur_kind  <= bus_kind_e'(req_kind);
               cur_addr  <= req_addr;
               cur_word  <= req_word;
               cur_wdata <= req_wdata;
               cur_seg   <= req_seg;
               cur_lock  <= req_lock;
               second    <= 1'b0;
               st        <= S_T1;
            end
            S_T1: st <= S_T2;
            S_T2: st <= S_T3;
            S_T3, S_TW: begin
               if (ready) begin
                  st <= S_T4;
                  if (kind_captures(cur_kind)) begin
                     if (full_word)    rdata <= ad_in;
                     else if (!second) rdata <= {{LANE_W{1'b0}}, rd_byte};
                     else              rdata[DATA_W-1:LANE_W] <= rd_byte;
                  end
               end else begin
                  st <= S_TW;
               end
            end
            S_T4: begin
               if (first_of_two) begin
                  second <= 1'b1;
                  st     <= S_T1;
               end else begin
                  st <= S_TI;
               end
            end
            default: st <= S_TI;
         endcase
      end
   end

   // R6: a request must carry a real cycle kind
   a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TI && req_valid) |-> (req_kind != 3'b111));

   // R8: the second half of a split word starts straight after the first
   a_r8_split_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_T4 && first_of_two) |=> (st == S_T1 && second));

   // R1: a wait clock only follows a low ready
   a_r1_wait_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_T3 && !ready) |=> (st == S_TW));
endmodule

// File: rtl/muxbus_cycle_seq.sv
module muxbus_cycle_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int DATA_W   = 16,
   parameter int SEG_W    = 2,
   parameter bit DEN_MID  = 1'b1,
   localparam int HI_W    = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic              req_lock,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic [HI_W-1:0]   a_hi,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              inta_n,
   output logic              dt_r,
   output logic              m_io,
   output logic              den_n,
   output logic [2:0]        bus_status,
   output logic              bhe_n,
   output logic              lock_n,
   input  logic              ready
);
   generate
      if (DATA_W != 16) begin : g_bad_data
         $error("muxbus_cycle_seq: DATA_W must be 16 (two byte lanes)");
      end
      if (HI_W < SEG_W) begin : g_bad_hi
         $error("muxbus_cycle_seq: upper address lines too few for segment tag");
      end
   endgenerate

   tstate_e              st;
   bus_kind_e            cur_kind, rq_kind;
   logic [ADDR_W-1:0]    cur_addr, eff_addr;
   logic                 cur_word, cur_lock, second, first_of_two, full_word, lane_bhe_n;
   logic [DATA_W-1:0]    cur_wdata, wr_bus;
   logic [SEG_W-1:0]     cur_seg;
   logic [DATA_W/2-1:0]  rd_byte;
   logic                 strobe_win, den_busy, den_early;

   assign rq_kind = bus_kind_e'(req_kind);

   mbs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
      .req_seg(req_seg), .req_lock(req_lock), .ready(ready),
      .full_word(full_word), .rd_byte(rd_byte), .ad_in(ad_in),
      .st(st), .cur_kind(cur_kind), .cur_addr(cur_addr), .cur_word(cur_word),
      .cur_wdata(cur_wdata), .cur_seg(cur_seg), .cur_lock(cur_lock),
      .second(second), .first_of_two(first_of_two), .done(done), .rdata(rdata)
   );

   mbs_lane_steer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_steer (
      .base_addr(cur_addr), .word(cur_word), .second(second), .wdata(cur_wdata),
      .ad_in(ad_in), .eff_addr(eff_addr), .full_word(full_word),
      .bhe_n(lane_bhe_n), .wr_bus(wr_bus), .rd_byte(rd_byte)
   );

   assign strobe_win = (st == S_T2) || (st == S_T3) || (st == S_TW);
   assign den_busy   = strobe_win && kind_has_den(cur_kind);
   assign den_early  = kind_is_write(cur_kind);

   mbs_den_gen #(.MID_EDGE(DEN_MID)) u_den (
      .clk(clk), .rst_n(rst_n), .busy(den_busy), .early(den_early), .den_n(den_n)
   );

   always_comb begin
      ale        = 1'b0;
      rd_n       = 1'b1;
      wr_n       = 1'b1;
      inta_n     = 1'b1;
      ad_oe      = 1'b0;
      ad_out     = '0;
      a_hi       = '0;
      bus_status = K_NONE;
      m_io       = 1'b0;
      dt_r       = 1'b0;
      bhe_n      = 1'b1;
      lock_n     = 1'b1;
      if (st == S_TI) begin
         if (req_valid) begin
            bus_status = rq_kind;
            m_io       = kind_is_mem(rq_kind);
            dt_r       = kind_is_write(rq_kind);
         end
      end else begin
         m_io   = kind_is_mem(cur_kind);
         dt_r   = kind_is_write(cur_kind);
         bhe_n  = lane_bhe_n;
         lock_n = !cur_lock;
         if (st == S_T1) begin
            ale        = 1'b1;
            bus_status = cur_kind;
            ad_oe      = 1'b1;
            ad_out     = eff_addr[DATA_W-1:0];
            a_hi       = kind_is_mem(cur_kind) ? eff_addr[ADDR_W-1:DATA_W] : '0;
         end else begin
            a_hi   = HI_W'(cur_seg);
            ad_oe  = kind_is_write(cur_kind);
            ad_out = kind_is_write(cur_kind) ? wr_bus : '0;
            case (st)
               S_T2:       bus_status = cur_kind;
               S_T3, S_TW: bus_status = ready ? K_NONE : cur_kind;
               default:    bus_status = first_of_two ? cur_kind : K_NONE;
            endcase
         end
         if (strobe_win) begin
            rd_n   = !kind_is_rdstrobe(cur_kind);
            wr_n   = !kind_is_write(cur_kind);
            inta_n = !(cur_kind == K_INTA);
         end
      end
   end

   // R2: the latch strobe lasts one clock
   a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R3: never more than one strobe at a time, and none during T1
   a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);
   a_r3_quiet_t1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wr_n && inta_n));

   // R4: a read strobe is always covered by the transceiver enable
   a_r4_rd_has_den: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !den_n);

   // R6: a cycle never opens with a passive status
   a_r6_status_t1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (bus_status != 3'b111));

   // R11: completion is a single-clock pulse
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12: the lock persists until the request completes
   a_r12_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_n && !done) |=> !lock_n);
endmodule

// File: tb/muxbus_cycle_seq_test.sv
`timescale 1ns/100ps
module muxbus_cycle_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'b111;
   logic [19:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_seg = '0;
   logic        req_lock = 1'b0;
   logic        done;
   logic [15:0] rdata, ad_out;
   logic        ad_oe;
   logic [15:0] ad_in = '0;
   logic [3:0]  a_hi;
   logic        ale, rd_n, wr_n, inta_n, dt_r, m_io, den_n, bhe_n, lock_n;
   logic [2:0]  bus_status;
   logic        ready = 1'b1;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   muxbus_cycle_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
      .req_seg(req_seg), .req_lock(req_lock), .done(done), .rdata(rdata),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi), .ale(ale),
      .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .dt_r(dt_r), .m_io(m_io),
      .den_n(den_n), .bus_status(bus_status), .bhe_n(bhe_n), .lock_n(lock_n),
      .ready(ready)
   );

   typedef struct {
      logic [2:0]  kind;
      logic [19:0] addr;
      logic        bhe_n;
      logic [15:0] wmask;
      logic [15:0] wexp;
      logic [1:0]  seg;
      logic        lock;
      logic        last;
      int          waits;
   } cyc_t;

   cyc_t q[$];

   function automatic logic rdk(input logic [2:0] k);  return k == 3'd1 || k == 3'd4 || k == 3'd5; endfunction
   function automatic logic wrk(input logic [2:0] k);  return k == 3'd2 || k == 3'd6; endfunction
   function automatic logic denk(input logic [2:0] k); return k != 3'd3; endfunction
   function automatic logic capk(input logic [2:0] k); return rdk(k) || k == 3'd0; endfunction
   function automatic logic memk(input logic [2:0] k); return k[2] && k != 3'd7; endfunction
   function automatic logic [7:0] fb(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
      end
   endtask

   // driver: pushes the expected bus cycles, then presents the request
   task automatic do_req(input logic [2:0] k, input logic [19:0] a, input logic w,
                         input logic [15:0] wd, input logic [1:0] sg, input logic lk,
                         input int nw);
      cyc_t c;
      logic [19:0] a1;
      logic [15:0] exp_rd;
      int guard;
      a1 = a + 20'd1;
      c.kind = k; c.seg = sg; c.lock = lk; c.waits = nw;
      if (w && a[0]) begin
         c.addr = a;  c.bhe_n = 1'b0; c.wmask = 16'hFF00; c.wexp = {wd[7:0], 8'h00};  c.last = 1'b0;
         q.push_back(c);
         c.addr = a1; c.bhe_n = 1'b1; c.wmask = 16'h00FF; c.wexp = {8'h00, wd[15:8]}; c.last = 1'b1;
         q.push_back(c);
      end else begin
         c.addr = a; c.last = 1'b1;
         if (w)         begin c.bhe_n = 1'b0; c.wmask = 16'hFFFF; c.wexp = wd; end
         else if (a[0]) begin c.bhe_n = 1'b0; c.wmask = 16'hFF00; c.wexp = {wd[7:0], 8'h00}; end
         else           begin c.bhe_n = 1'b1; c.wmask = 16'h00FF; c.wexp = {8'h00, wd[7:0]}; end
         q.push_back(c);
      end
      req_kind = k; req_addr = a; req_word = w; req_wdata = wd; req_seg = sg; req_lock = lk;
      req_valid = 1'b1;
      guard = 0;
      forever begin
         @(posedge clk); #1.5;
         if (done) break;
         guard++;
         if (guard > 200) begin chk("R1 request never completed", 0, 1); break; end
      end
      if (capk(k)) begin
         exp_rd = w ? {fb(a1), fb(a)} : {8'h00, fb(a)};
         chk(w && a[0] ? "R8 R11 split word read data" : "R11 read data", rdata, exp_rd);
      end
      req_valid = 1'b0;
   endtask

   // monitor: tracks T-states from ale and the ready it drove
   typedef enum int {P_I, P_1, P_2, P_3, P_W, P_4} ph_e;
   ph_e  ph = P_I;
   cyc_t it;
   int   wl = 0;
   logic rdy_edge;

   initial begin
      forever begin
         @(posedge clk); #1;
         if (!rst_n) begin
            ph = P_I;
         end else begin
            rdy_edge = ready;
            if (ph == P_I || ph == P_4)      ph = ale ? P_1 : P_I;
            else if (ph == P_1)              ph = P_2;
            else if (ph == P_2)              ph = P_3;
            else                             ph = rdy_edge ? P_4 : P_W;
            if (ph == P_1) begin
               if (q.size() == 0) chk("R1 unexpected cycle start", 1, 0);
               else it = q.pop_front();
            end else begin
               chk("R2 ale only in T1", ale, 0);
            end
            if (ph == P_I) begin
               chk("R10 idle rd_n", rd_n, 1);
               chk("R10 idle wr_n", wr_n, 1);
               chk("R10 idle inta_n", inta_n, 1);
               chk("R10 idle den_n", den_n, 1);
               chk("R10 idle lock_n", lock_n, 1);
               chk("R10 R6 idle status", bus_status, req_valid ? {29'd0, req_kind} : 32'd7);
               if (req_valid) begin
                  chk("R5 m_io ahead of T1", m_io, memk(req_kind));
                  chk("R5 dt_r ahead of T1", dt_r, wrk(req_kind));
               end
            end else begin
               chk("R7 bhe_n", bhe_n, it.bhe_n);
               chk("R12 lock_n", lock_n, !it.lock);
               chk("R5 m_io", m_io, memk(it.kind));
               chk("R5 dt_r", dt_r, wrk(it.kind));
               chk("R1 done", done, (ph == P_4) && it.last);
               if (ph == P_1) begin
                  chk("R6 status T1", bus_status, it.kind);
                  chk("R3 no strobe in T1", {rd_n, wr_n, inta_n}, 3'b111);
                  chk("R2 ad_oe T1", ad_oe, 1);
                  chk("R2 R8 address T1", ad_out, it.addr[15:0]);
                  chk("R2 upper address T1", a_hi, memk(it.kind) ? it.addr[19:16] : 4'h0);
                  chk("R4 den_n T1", den_n, 1);
                  ad_in = {fb(it.addr | 20'd1), fb(it.addr & ~20'd1)};
               end else begin
                  chk("R9 segment tag", a_hi, {2'b00, it.seg});
                  chk("R7 ad_oe data phase", ad_oe, wrk(it.kind));
                  if (wrk(it.kind)) chk("R7 R8 write lane", ad_out & it.wmask, it.wexp);
                  if (ph == P_4) begin
                     chk("R3 no strobe in T4", {rd_n, wr_n, inta_n}, 3'b111);
                     chk("R4 den_n early T4", den_n, !denk(it.kind));
                  end else begin
                     chk("R3 rd_n", rd_n, !rdk(it.kind));
                     chk("R3 wr_n", wr_n, !wrk(it.kind));
                     chk("R3 inta_n", inta_n, it.kind != 3'd0);
                     if (ph == P_2) begin
                        chk("R6 status T2", bus_status, it.kind);
                        chk("R4 den_n early T2", den_n, !wrk(it.kind));
                        wl = it.waits;
                        ready = (wl == 0);
                     end else begin
                        chk("R4 den_n early T3/TW", den_n, !denk(it.kind));
                        if (ph == P_W) begin
                           wl--;
                           ready = (wl <= 0);
                        end
                     end
                  end
               end
            end
            #2;
            if (ph == P_I) begin
               chk("R10 idle den_n late", den_n, 1);
               chk("R10 idle status late", bus_status, req_valid ? {29'd0, req_kind} : 32'd7);
            end else if (ph == P_1) begin
               chk("R4 den_n late T1", den_n, 1);
            end else if (ph == P_2) begin
               chk("R4 den_n mid T2", den_n, !denk(it.kind));
            end else if (ph == P_3 || ph == P_W) begin
               chk("R4 den_n late T3/TW", den_n, !denk(it.kind));
               chk("R6 status T3/TW", bus_status, ready ? 32'd7 : {29'd0, it.kind});
            end else begin
               chk("R4 den_n mid T4", den_n, 1);
               chk("R6 status T4", bus_status, it.last ? 32'd7 : {29'd0, it.kind});
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset ale", ale, 0);
      chk("R10 reset status", bus_status, 3'b111);
      chk("R10 reset strobes", {rd_n, wr_n, inta_n}, 3'b111);
      chk("R10 reset den_n", den_n, 1);
      chk("R11 reset done", done, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(posedge clk); #1.5;
      do_req(3'd5, 20'h12344, 1'b1, 16'h0000, 2'd3, 1'b0, 0);  // R1 aligned word read
      do_req(3'd6, 20'h00A10, 1'b0, 16'h00C3, 2'd1, 1'b0, 2);  // R7 even byte write, waits
      do_req(3'd6, 20'h00A11, 1'b0, 16'h005E, 2'd1, 1'b0, 0);  // R7 odd byte write
      do_req(3'd5, 20'h3F2E7, 1'b0, 16'h0000, 2'd0, 1'b0, 1);  // R11 odd byte read
      do_req(3'd1, 20'hABCD4, 1'b1, 16'h0000, 2'd2, 1'b0, 0);  // R2 IO upper lines zero
      do_req(3'd2, 20'h00301, 1'b1, 16'hBEEF, 2'd2, 1'b0, 1);  // R8 split IO write
      do_req(3'd5, 20'hFFFFF, 1'b1, 16'h0000, 2'd3, 1'b0, 2);  // R8 split read with wrap
      do_req(3'd4, 20'h0F0F0, 1'b1, 16'h0000, 2'd2, 1'b0, 0);  // R3 fetch
      do_req(3'd0, 20'h00000, 1'b0, 16'h0000, 2'd2, 1'b0, 1);  // R3 acknowledge
      do_req(3'd3, 20'h00002, 1'b0, 16'h0000, 2'd2, 1'b0, 0);  // R3 R4 halt: no strobe
      do_req(3'd6, 20'h54321, 1'b1, 16'h1234, 2'd3, 1'b1, 1);  // R12 locked split write
      repeat (6) @(posedge clk); #1.5;                          // R10 idle stretch
      for (int i = 0; i < 24; i++) begin
         do_req(3'(((i % 4) == 0) ? 1 : ((i % 4) == 1) ? 2 : ((i % 4) == 2) ? 5 : 6),
                20'h1000 + 20'(i * 37), (i % 3) != 0, 16'(16'hA5C3 ^ (i * 16'h0911)),
                2'(i), (i % 5) == 0, i % 3);
         if ((i % 6) == 5) begin repeat (2) @(posedge clk); #1.5; end
      end
      repeat (4) @(posedge clk); #1.5;
      chk("R1 all expected cycles seen", q.size(), 0);
      summary();
      $finish;
   end
endmodule